// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block receives configuration words over a three-wire serial link: a data line, a serial clock and a latch strobe. All three lines are asynchronous to the system clock and are brought into its domain by synchronizer chains. Each rising edge of the serial clock shifts one bit into a 16-bit shift register, most significant bit first. A rising edge on the latch line then commits the word. The two lowest bits of the word choose the destination, and the upper fourteen bits become that register's contents.

There are three destinations: a left volume register, a right volume register and a control register. The control fields are brought out as decoded outputs. The interpolation selects, the mute and the serial format are each ORed with a matching hardware pin, so a board can run without the serial link. Each committed volume write raises a single-cycle strobe for the downstream gain stage. The port is write-only; nothing can be read back.

Top module: `wr3_ctl_port`

## Requirements
- R1: While `rst` is high and in the cycles after it, both volume outputs are 14'h3FFF, `vol_upd` is 0, and every control output is 0 when the pins are low. Reset also clears the shift register.
- R2: A committed word with bits [1:0] = 00 loads its bits [15:2] into `vol_left`. Bits are taken MSB first, one on each rising edge of `ctl_sclk`.
- R3: A committed word with bits [1:0] = 10 loads its bits [15:2] into `vol_right`.
- R4: A committed word with bits [1:0] = 01 loads the control register with the following word bits: 11 → 2x interpolation, 10 → 4x interpolation, 9:8 → word length, 7 → soft reset, 6 → mute, 5:4 → serial format, 3:2 → de-emphasis select.
- R5: A committed word with bits [1:0] = 11 changes no output and raises no `vol_upd`.
- R6: Bits [15:12] of a control word have no effect on any output.
- R7: `intp_x2`, `intp_x4`, `mute` and each bit of `ser_fmt` are the OR of the register field and the matching pin. Each follows a pin change within three system clocks, with no serial write needed.
- R8: Each volume write produces exactly one `vol_upd` pulse, one cycle long, in the cycle the volume output changes. A control write produces no pulse.
- R9: Serial clock edges without a rising latch edge leave every output unchanged.
- R10: If the count of bits shifted before a latch edge is other than 16, the last 16 bits shifted in form the committed word, and this may include bits left over from earlier words.
- R11: If a latch rising edge and a serial clock rising edge reach the system domain in the same cycle, the commit uses the 16 bits shifted before that edge. The coincident bit becomes the first bit of the next word.
- R12: Asserting `rst` partway through a word discards the partial bits, and all registers return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sclk | input | 1 | Serial bit clock, asynchronous |
| ctl_sdat | input | 1 | Serial data, MSB first, asynchronous |
| ctl_latch | input | 1 | Commit strobe; the rising edge writes the word |
| pin_x2 | input | 1 | Hardware 2x interpolation select |
| pin_x4 | input | 1 | Hardware 4x interpolation select |
| pin_mute | input | 1 | Hardware mute |
| pin_fmt | input | 2 | Hardware serial format select |
| vol_left | output | 14 | Left channel gain word |
| vol_right | output | 14 | Right channel gain word |
| vol_upd | output | 1 | One-cycle strobe on each volume write |
| intp_x2 | output | 1 | 2x interpolation (register OR pin) |
| intp_x4 | output | 1 | 4x interpolation (register OR pin) |
| word_len | output | 2 | Word length code |
| soft_rst | output | 1 | Soft reset field |
| mute | output | 1 | Mute (register OR pin) |
| ser_fmt | output | 2 | Serial format (register OR pins) |
| deemph | output | 2 | De-emphasis select |

## Verification
With a continuously running serial clock, the latch commit and a serial shift can land in the same system cycle. The bench provokes this by raising `ctl_sclk` and `ctl_latch` on the same system-clock edge. It judges the result twice. First, the committed left volume must equal the previous 16 bits. Second, a following latch must commit a right-volume word whose MSB is the coincident bit. The bench also changes the hardware pins while a control word is being committed and checks the ORed outputs against a model of the register contents.

// File: rtl/wr3_pkg.sv
package wr3_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;
  localparam int DATA_W = WORD_W - ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    ADR_VOL_L = 2'b00,
    ADR_CTL   = 2'b01,
    ADR_VOL_R = 2'b10,
    ADR_NONE  = 2'b11
  } adr_e;

  typedef struct packed {
    logic       x2;
    logic       x4;
    logic [1:0] wlen;
    logic       srst;
    logic       mute;
    logic [1:0] fmt;
    logic [1:0] deemph;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/wr3_sync.sv
module wr3_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/wr3_shifter.sv
module wr3_shifter #(
  parameter int WORD_W = wr3_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/wr3_regbank.sv
module wr3_regbank
  import wr3_pkg::*;
#(
  parameter int WORD_W = wr3_pkg::WORD_W,
  parameter int ADDR_W = wr3_pkg::ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit,
  input  logic [WORD_W-1:0]        word,
  output logic [WORD_W-ADDR_W-1:0] vol_l,
  output logic [WORD_W-ADDR_W-1:0] vol_r,
  output ctl_t                     ctl,
  output logic                     vol_upd,
  output logic                     ctl_wr
);
  localparam int DW = WORD_W - ADDR_W;

  adr_e          adr;
  logic [DW-1:0] data;

  assign adr  = adr_e'(word[ADDR_W-1:0]);
  assign data = word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_l   <= '1;
      vol_r   <= '1;
      ctl     <= '0;
      vol_upd <= 1'b0;
      ctl_wr  <= 1'b0;
    end else begin
      vol_upd <= 1'b0;
      ctl_wr  <= 1'b0;
      if (commit) begin
        case (adr)
          ADR_VOL_L: begin vol_l <= data; vol_upd <= 1'b1; end
          ADR_VOL_R: begin vol_r <= data; vol_upd <= 1'b1; end
          ADR_CTL:   begin ctl <= ctl_t'(data[CTL_W-1:0]); ctl_wr <= 1'b1; end
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wr3_ctl_port.sv
module wr3_ctl_port
  import wr3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_sclk,
  input  logic              ctl_sdat,
  input  logic              ctl_latch,
  input  logic              pin_x2,
  input  logic              pin_x4,
  input  logic              pin_mute,
  input  logic [1:0]        pin_fmt,
  output logic [DATA_W-1:0] vol_left,
  output logic [DATA_W-1:0] vol_right,
  output logic              vol_upd,
  output logic              intp_x2,
  output logic              intp_x4,
  output logic [1:0]        word_len,
  output logic              soft_rst,
  output logic              mute,
  output logic [1:0]        ser_fmt,
  output logic [1:0]        deemph
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] s_lvl, s_rise;
  logic [WORD_W-1:0] sh_word;
  ctl_t              ctl_q;
  logic              ctl_wr;

  // line order: {latch, data, clock}
  wr3_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .din({ctl_latch, ctl_sdat, ctl_sclk}),
    .lvl(s_lvl), .rise(s_rise)
  );

  wr3_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst),
    .shift_en(s_rise[0]), .bit_in(s_lvl[1]),
    .word(sh_word)
  );

  // commit sees the word as it stood before a coincident shift (R11)
  wr3_regbank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst(rst),
    .commit(s_rise[2]), .word(sh_word),
    .vol_l(vol_left), .vol_r(vol_right), .ctl(ctl_q),
    .vol_upd(vol_upd), .ctl_wr(ctl_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      intp_x2  <= 1'b0;
      intp_x4  <= 1'b0;
      word_len <= '0;
      soft_rst <= 1'b0;
      mute     <= 1'b0;
      ser_fmt  <= '0;
      deemph   <= '0;
    end else begin
      intp_x2  <= ctl_q.x2 | pin_x2;
      intp_x4  <= ctl_q.x4 | pin_x4;
      word_len <= ctl_q.wlen;
      soft_rst <= ctl_q.srst;
      mute     <= ctl_q.mute | pin_mute;
      ser_fmt  <= ctl_q.fmt | pin_fmt;
      deemph   <= ctl_q.deemph;
    end
  end
endmodule

// File: rtl/wr3_ctl_port_chk.sv
module wr3_ctl_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        pin_mute,
  input logic        mute,
  input logic        vol_upd,
  input logic        ctl_wr,
  input logic [13:0] vol_left,
  input logic [13:0] vol_right,
  input logic [1:0]  word_len,
  input logic [1:0]  deemph,
  input logic        soft_rst
);
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vol_left == 14'h3FFF && vol_right == 14'h3FFF && !vol_upd));

  assert_upd_single_R8: assert property (@(posedge clk) disable iff (rst)
    vol_upd |=> !vol_upd);

  assert_vol_change_upd_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (vol_left != $past(vol_left) || vol_right != $past(vol_right))) |-> vol_upd);

  assert_ctl_change_wr_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($stable(word_len) && $stable(deemph) && $stable(soft_rst))) |-> $past(ctl_wr));

  assert_mute_pin_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_mute)) |-> mute);
endmodule

bind wr3_ctl_port wr3_ctl_port_chk chk_i (
  .clk(clk), .rst(rst), .pin_mute(pin_mute), .mute(mute),
  .vol_upd(vol_upd), .ctl_wr(ctl_wr),
  .vol_left(vol_left), .vol_right(vol_right),
  .word_len(word_len), .deemph(deemph), .soft_rst(soft_rst)
);

// File: tb/wr3_ctl_port_tb.sv
module wr3_ctl_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_sclk = 1'b0, ctl_sdat = 1'b0, ctl_latch = 1'b0;
  logic pin_x2 = 1'b0, pin_x4 = 1'b0, pin_mute = 1'b0;
  logic [1:0] pin_fmt = 2'b00;
  logic [13:0] vol_left, vol_right;
  logic vol_upd, intp_x2, intp_x4, soft_rst, mute;
  logic [1:0] word_len, ser_fmt, deemph;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr3_ctl_port dut_i (
    .clk(clk), .rst(rst), .ctl_sclk(ctl_sclk), .ctl_sdat(ctl_sdat),
    .ctl_latch(ctl_latch), .pin_x2(pin_x2), .pin_x4(pin_x4),
    .pin_mute(pin_mute), .pin_fmt(pin_fmt),
    .vol_left(vol_left), .vol_right(vol_right), .vol_upd(vol_upd),
    .intp_x2(intp_x2), .intp_x4(intp_x4), .word_len(word_len),
    .soft_rst(soft_rst), .mute(mute), .ser_fmt(ser_fmt), .deemph(deemph)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic cnt_clr = 1'b0;
  int upd_cnt = 0;

  always @(posedge clk) begin
    if (cnt_clr) upd_cnt <= 0;
    else if (vol_upd) upd_cnt <= upd_cnt + 1;
  end

  // reference state
  logic [13:0] m_vl = 14'h3FFF, m_vr = 14'h3FFF;
  logic [9:0]  m_ctl = '0;

  // vector: {word[15:0], pins {x2,x4,mute,fmt[1:0]}}
  localparam logic [20:0] VEC [8] = '{
    {16'h48D0, 5'b00000},
    {16'hAAD6, 5'b00000},
    {16'hA5AD, 5'b00000},
    {16'h4447, 5'b00000},
    {16'h0001, 5'b10101},
    {16'h0000, 5'b00000},
    {16'h0FFD, 5'b00000},
    {16'h0006, 5'b00010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ctl_sclk = 1'b0; ctl_sdat = v[i];
      wait_n(PH);
      ctl_sclk = 1'b1;
      wait_n(PH);
    end
  endtask

  task automatic do_latch();
    @(negedge clk); ctl_latch = 1'b1;
    wait_n(PH);
    ctl_latch = 1'b0;
    wait_n(PH + 8);
  endtask

  task automatic clr_cnt();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  function automatic logic [9:0] ctl_out();
    return {intp_x2, intp_x4, word_len, soft_rst, mute, ser_fmt, deemph};
  endfunction

  function automatic logic [9:0] ctl_exp(input logic [4:0] p);
    return {m_ctl[9] | p[4], m_ctl[8] | p[3], m_ctl[7:6], m_ctl[5],
            m_ctl[4] | p[2], m_ctl[3:2] | p[1:0], m_ctl[1:0]};
  endfunction

  task automatic model_write(input logic [15:0] w);
    case (w[1:0])
      2'b00: m_vl = w[15:2];
      2'b10: m_vr = w[15:2];
      2'b01: m_ctl = w[11:2];
      default: ;
    endcase
  endtask

  task automatic reset_dut();
    @(negedge clk); rst = 1'b1; ctl_sclk = 1'b0; ctl_sdat = 1'b0; ctl_latch = 1'b0;
    wait_n(4);
    rst = 1'b0;
    m_vl = 14'h3FFF; m_vr = 14'h3FFF; m_ctl = '0;
    wait_n(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    // R1 reset state
    chk("R1 vol_left", vol_left, 14'h3FFF);
    chk("R1 vol_right", vol_right, 14'h3FFF);
    chk("R1 ctl", ctl_out(), 10'h000);
    chk("R1 vol_upd", vol_upd, 1'b0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      logic [4:0]  p;
      string tg;
      {w, p} = VEC[i];
      {pin_x2, pin_x4, pin_mute, pin_fmt} = p;
      clr_cnt();
      send_bits({16'h0, w}, 16);
      do_latch();
      model_write(w);
      case (w[1:0])
        2'b00: tg = "R2";
        2'b10: tg = "R3";
        2'b01: tg = "R4 R6";
        default: tg = "R5";
      endcase
      chk({tg, " vol_left"}, vol_left, m_vl);
      chk({tg, " vol_right"}, vol_right, m_vr);
      chk({tg, " R7 ctl"}, ctl_out(), ctl_exp(p));
      chk({tg, " R8 upd count"}, upd_cnt, (w[1:0] == 2'b00 || w[1:0] == 2'b10) ? 1 : 0);
    end
    {pin_x2, pin_x4, pin_mute, pin_fmt} = 5'b0;
    wait_n(4);

    // R9 clocks without latch
    clr_cnt();
    send_bits(32'hFF34, 16);
    wait_n(10);
    chk("R9 vol_left", vol_left, m_vl);
    chk("R9 vol_right", vol_right, m_vr);
    chk("R9 ctl", ctl_out(), ctl_exp(5'b0));
    chk("R9 upd count", upd_cnt, 0);

    // R10 fewer bits: last 16 = {34, 04}
    send_bits(32'h04, 8);
    do_latch();
    chk("R10 short word", vol_left, 14'h0D01);
    chk("R10 upd count", upd_cnt, 1);
    // R10 more bits
    send_bits(32'hF0554, 20);
    do_latch();
    chk("R10 long word", vol_left, 14'h0155);

    // R11 coincident latch and clock edges
    send_bits(32'h2AA8, 16);
    @(negedge clk); ctl_sclk = 1'b0; ctl_sdat = 1'b1;
    wait_n(PH);
    ctl_sclk = 1'b1; ctl_latch = 1'b1;
    wait_n(PH);
    ctl_latch = 1'b0;
    wait_n(PH + 8);
    chk("R11 commit uses prior bits", vol_left, 14'h0AAA);
    send_bits(32'h4002, 15);
    do_latch();
    chk("R11 coincident bit starts next word", vol_right, 14'h3000);

    // R7 pin only
    send_bits(32'h0001, 16);
    do_latch();
    @(negedge clk); pin_x4 = 1'b1; pin_mute = 1'b1; pin_fmt = 2'b11;
    wait_n(3);
    chk("R7 pins raise outputs", {intp_x4, mute, ser_fmt}, 4'b1111);
    @(negedge clk); pin_x4 = 1'b0; pin_mute = 1'b0; pin_fmt = 2'b00;
    wait_n(3);
    chk("R7 pins release outputs", {intp_x4, mute, ser_fmt}, 4'b0000);

    // R12 reset mid-word
    send_bits(32'hA5, 8);
    reset_dut();
    chk("R12 vol_left", vol_left, 14'h3FFF);
    chk("R12 vol_right", vol_right, 14'h3FFF);
    chk("R12 ctl", ctl_out(), 10'h000);
    send_bits(32'h06, 8);
    do_latch();
    chk("R12 partial bits discarded", vol_right, 14'h0001);
    chk("R12 left untouched", vol_left, 14'h3FFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule